// File: doc/BRIEF.md
# T1 Receive Resync and Carrier-Loss Controller

This block sits next to the frame aligner of a T1 receiver. It decides when a new frame-alignment search begins, and it drives two alarms: loss of sync and loss of carrier. It watches the received bit stream for long runs of zeros and declares carrier loss after a fixed count. It withdraws that alarm only after the line has shown a sustained minimum ones density.

Several sources can start a new search, and each is gated by a mode bit:
- an out-of-frame event reported at the F-bit time;
- the onset of carrier loss;
- a rising edge on a manual trigger bit;
- the release of reset.

Each accepted trigger produces a one-cycle request to the aligner and opens a search window. The window closes when the aligner reports that it has found the frame. A trigger that arrives while a search is open is dropped.

The received bits enter on a valid/ready stream. The block never applies back-pressure: `rx_ready` is held high and a bit is consumed in every cycle where `rx_valid` is high. Cycles with `rx_valid` low do not touch the carrier-loss state. The other pins are plain level or pulse signals sampled on the rising clock edge.

Top module: `t1_resync_ctl`

## Requirements
- R1: An active-low asynchronous reset clears all state, so that `resync_req`, `search_on`, `los` and `carrier_loss` read 0. On the first clock edge after release, `resync_req` pulses and `search_on` rises, whatever the mode bits are.
- R2: `carrier_loss` rises at the clock edge that accepts the 192nd consecutive zero bit. 191 consecutive zeros leave it low.
- R3: While `carrier_loss` is high, it falls at the edge that completes 32 consecutive accepted bits during which the running count of consecutive zeros never reaches 8. A run of 8 zeros restarts that count.
- R4: With `auto_dis` low, `oof_evt` high together with `fbit_mark` high sets `los` and issues `resync_req` at that edge. `oof_evt` without `fbit_mark` has no effect.
- R5: With `auto_dis` low and `cl_resync_dis` low, the edge where `carrier_loss` rises also sets `los` and issues `resync_req`. With `cl_resync_dis` high, carrier loss starts no resync.
- R6: With `auto_dis` high, `los` reads 0 one cycle later and stays 0. Out-of-frame events and carrier loss then start no resync.
- R7: A 0-to-1 transition of `man_trig` between two sampling edges starts a resync in either mode. Holding `man_trig` high starts no further resync.
- R8: `resync_req` is high for exactly one cycle per accepted trigger. Any trigger seen while `search_on` is high is ignored.
- R9: `frame_found` high while a search is open clears `search_on` and `los` at that edge.
- R10: `rx_ready` is always 1. While `rx_valid` is 0, `rx_bit` has no effect on `carrier_loss` or on the zero-run and density counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts a resync |
| rx_valid | input | 1 | Received bit present this cycle |
| rx_ready | output | 1 | Always 1; no back-pressure |
| rx_bit | input | 1 | Received data bit |
| oof_evt | input | 1 | Out-of-frame event from the frame checker |
| fbit_mark | input | 1 | Marks the F-bit time slot |
| frame_found | input | 1 | Aligner reports frame alignment achieved |
| auto_dis | input | 1 | 1 disables automatic resync and the loss-of-sync alarm |
| cl_resync_dis | input | 1 | 1 stops carrier loss from starting a resync |
| man_trig | input | 1 | Manual resync trigger, rising edge active |
| resync_req | output | 1 | One-cycle request to start alignment search |
| search_on | output | 1 | Alignment search in progress |
| los | output | 1 | Loss-of-sync alarm |
| carrier_loss | output | 1 | Carrier-loss alarm |

## Verification
The hardest state to reach is the release of carrier loss. The density rule needs a long zero run to set the alarm, then a stretch of at least 32 bits with no run of eight zeros, with idle stream cycles mixed in that must not count. The directed part of the stimulus sends exactly 191 and then 192 zeros, then a one in every eighth bit, and checks the alarm at the 31st and 32nd qualifying bits. The random part switches among sparse, medium and dense ones densities in long phases, so that the alarm sets and clears many times while resync triggers and mode changes land around it.

// File: rtl/t1rs_pkg.sv
package t1rs_pkg;
  typedef struct packed {
    logic auto_hit;
    logic man_hit;
    logic boot_hit;
  } trig_t;
endpackage

// File: rtl/t1rs_carrier.sv
module t1rs_carrier #(
  parameter int ZERO_LIM  = 192,
  parameter int RUN_LEN   = 8,
  parameter int DENS_SPAN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_val,
  output logic cl,
  output logic cl_rise
);
  localparam int ZW = $clog2(ZERO_LIM + 1);
  localparam int DW = $clog2(DENS_SPAN + 1);

  logic [ZW-1:0] zrun_q, zrun_n;
  logic [DW-1:0] ok_q, ok_n;
  logic          cl_q, cl_n;

  always_comb begin
    zrun_n = zrun_q;
    ok_n   = ok_q;
    cl_n   = cl_q;
    if (bit_vld) begin
      if (bit_val)                       zrun_n = '0;
      else if (zrun_q != ZW'(ZERO_LIM))  zrun_n = zrun_q + 1'b1;
      if (zrun_n >= ZW'(RUN_LEN))        ok_n = '0;
      else if (ok_q != DW'(DENS_SPAN))   ok_n = ok_q + 1'b1;
      if (zrun_n == ZW'(ZERO_LIM))                 cl_n = 1'b1;
      else if (cl_q && ok_n == DW'(DENS_SPAN))     cl_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun_q <= '0;
      ok_q   <= '0;
      cl_q   <= 1'b0;
    end else begin
      zrun_q <= zrun_n;
      ok_q   <= ok_n;
      cl_q   <= cl_n;
    end
  end

  assign cl      = cl_q;
  assign cl_rise = cl_n & ~cl_q;
endmodule

// File: rtl/t1rs_trig.sv
module t1rs_trig
  import t1rs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  oof_evt,
  input  logic  fbit_mark,
  input  logic  cl_rise,
  input  logic  auto_dis,
  input  logic  cl_resync_dis,
  input  logic  man_trig,
  output trig_t trig
);
  logic man_q;
  logic boot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_q  <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      man_q  <= man_trig;
      boot_q <= 1'b0;
    end
  end

  always_comb begin
    trig.auto_hit = ~auto_dis & ((oof_evt & fbit_mark) | (~cl_resync_dis & cl_rise));
    trig.man_hit  = man_trig & ~man_q;
    trig.boot_hit = boot_q;
  end
endmodule

// File: rtl/t1rs_seq.sv
module t1rs_seq
  import t1rs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_t trig,
  input  logic  frame_found,
  input  logic  auto_dis,
  output logic  resync_req,
  output logic  search_on,
  output logic  los
);
  logic accept;
  logic req_q, search_q, los_q;

  assign accept = (trig.auto_hit | trig.man_hit | trig.boot_hit) & ~search_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      search_q <= 1'b0;
      los_q    <= 1'b0;
    end else begin
      req_q <= accept;
      if (accept)           search_q <= 1'b1;
      else if (frame_found) search_q <= 1'b0;
      if (auto_dis)                    los_q <= 1'b0;
      else if (accept && trig.auto_hit) los_q <= 1'b1;
      else if (frame_found)            los_q <= 1'b0;
    end
  end

  assign resync_req = req_q;
  assign search_on  = search_q;
  assign los        = los_q;
endmodule

// File: rtl/t1_resync_ctl.sv
module t1_resync_ctl #(
  parameter int ZERO_LIM  = 192,
  parameter int RUN_LEN   = 8,
  parameter int DENS_SPAN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  output logic rx_ready,
  input  logic rx_bit,
  input  logic oof_evt,
  input  logic fbit_mark,
  input  logic frame_found,
  input  logic auto_dis,
  input  logic cl_resync_dis,
  input  logic man_trig,
  output logic resync_req,
  output logic search_on,
  output logic los,
  output logic carrier_loss
);
  import t1rs_pkg::*;

  logic  cl_rise;
  trig_t trig;

  assign rx_ready = 1'b1;

  t1rs_carrier #(
    .ZERO_LIM (ZERO_LIM),
    .RUN_LEN  (RUN_LEN),
    .DENS_SPAN(DENS_SPAN)
  ) u_carrier (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_vld(rx_valid),
    .bit_val(rx_bit),
    .cl     (carrier_loss),
    .cl_rise(cl_rise)
  );

  t1rs_trig u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .oof_evt      (oof_evt),
    .fbit_mark    (fbit_mark),
    .cl_rise      (cl_rise),
    .auto_dis     (auto_dis),
    .cl_resync_dis(cl_resync_dis),
    .man_trig     (man_trig),
    .trig         (trig)
  );

  t1rs_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .frame_found(frame_found),
    .auto_dis   (auto_dis),
    .resync_req (resync_req),
    .search_on  (search_on),
    .los        (los)
  );
endmodule

// File: rtl/t1rs_chk.sv
module t1rs_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic rx_bit,
  input logic frame_found,
  input logic auto_dis,
  input logic resync_req,
  input logic search_on,
  input logic los,
  input logic carrier_loss
);
  // R8
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |=> !resync_req);
  // R8
  search_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(search_on) |-> resync_req);
  // R6
  los_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_dis |=> !los);
  // R9
  los_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (los && frame_found) |=> !los);
  // R9
  search_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (search_on && !frame_found) |=> search_on);
  // R2
  cl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_loss) |-> $past(rx_valid && !rx_bit));
endmodule

bind t1_resync_ctl t1rs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .rx_bit      (rx_bit),
  .frame_found (frame_found),
  .auto_dis    (auto_dis),
  .resync_req  (resync_req),
  .search_on   (search_on),
  .los         (los),
  .carrier_loss(carrier_loss)
);

// File: tb/tb_t1_resync_ctl.sv
module tb_t1_resync_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_bit = 1'b0, oof_evt = 1'b0, fbit_mark = 1'b0;
  logic frame_found = 1'b0, auto_dis = 1'b0, cl_resync_dis = 1'b0, man_trig = 1'b0;
  logic rx_ready, resync_req, search_on, los, carrier_loss;

  int n_chk = 0, n_fail = 0;
  int m_zrun, m_ok;
  bit m_cl, m_man, m_boot, m_search, m_los, m_req;

  always #5 clk = ~clk;

  t1_resync_ctl dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_bit(rx_bit), .oof_evt(oof_evt), .fbit_mark(fbit_mark),
    .frame_found(frame_found), .auto_dis(auto_dis), .cl_resync_dis(cl_resync_dis),
    .man_trig(man_trig), .resync_req(resync_req), .search_on(search_on),
    .los(los), .carrier_loss(carrier_loss)
  );

  function automatic int nxt_zrun(input int z, input bit v, input bit b);
    if (!v) return z;
    if (b) return 0;
    return (z < 192) ? z + 1 : 192;
  endfunction

  task automatic chk(input logic act, input bit exp, input string tag, input string nm);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic cmp_all(input string tag);
    chk(rx_ready, 1'b1, tag, "rx_ready");
    chk(resync_req, m_req, tag, "resync_req");
    chk(search_on, m_search, tag, "search_on");
    chk(los, m_los, tag, "los");
    chk(carrier_loss, m_cl, tag, "carrier_loss");
  endtask

  task automatic model_reset();
    m_zrun = 0; m_ok = 0; m_cl = 0; m_man = 0; m_boot = 1;
    m_search = 0; m_los = 0; m_req = 0;
  endtask

  task automatic model_step();
    int  zn, okn;
    bit  cln, rise, ah, mh, acc;
    zn = nxt_zrun(m_zrun, rx_valid, rx_bit);
    okn = m_ok; cln = m_cl;
    if (rx_valid) begin
      okn = (zn >= 8) ? 0 : ((m_ok < 32) ? m_ok + 1 : 32);
      if (zn == 192) cln = 1;
      else if (m_cl && okn == 32) cln = 0;
    end
    rise = cln && !m_cl;
    ah = !auto_dis && ((oof_evt && fbit_mark) || (!cl_resync_dis && rise));
    mh = man_trig && !m_man;
    acc = (ah || mh || m_boot) && !m_search;
    if (auto_dis) m_los = 0;
    else if (acc && ah) m_los = 1;
    else if (frame_found) m_los = 0;
    if (acc) m_search = 1;
    else if (frame_found) m_search = 0;
    m_req = acc; m_man = man_trig; m_boot = 0;
    m_zrun = zn; m_ok = okn; m_cl = cln;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    #1 cmp_all(tag);
    @(negedge clk);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #2 cmp_all(tag);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic feed(input bit b, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_bit = b;
      tick(tag);
    end
    rx_valid = 1'b0; rx_bit = 1'b0;
  endtask

  task automatic close_search(input string tag);
    frame_found = 1'b1; tick(tag); frame_found = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    #2 cmp_all("R1 reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tick("R1 boot");
    chk(resync_req, 1'b1, "R1", "boot req");
    tick("R8 pulse");
    chk(resync_req, 1'b0, "R8", "single pulse");
    oof_evt = 1'b1; fbit_mark = 1'b1; tick("R8 ignored"); oof_evt = 1'b0; fbit_mark = 1'b0;
    chk(los, 1'b0, "R8", "trigger while searching");
    close_search("R9 close");
    chk(search_on, 1'b0, "R9", "search closed");
    oof_evt = 1'b1; tick("R4 no fbit"); oof_evt = 1'b0;
    chk(resync_req, 1'b0, "R4", "oof without fbit");
    oof_evt = 1'b1; fbit_mark = 1'b1; tick("R4 oof"); oof_evt = 1'b0; fbit_mark = 1'b0;
    chk(los, 1'b1, "R4", "los set");
    chk(resync_req, 1'b1, "R4", "req");
    tick("R8");
    close_search("R9 los");
    chk(los, 1'b0, "R9", "los cleared");
    feed(1'b0, 191, "R2 run");
    chk(carrier_loss, 1'b0, "R2", "191 zeros");
    rx_bit = 1'b1; tick("R10 idle"); rx_bit = 1'b0;
    feed(1'b0, 1, "R2 edge");
    chk(carrier_loss, 1'b1, "R2", "192 zeros");
    chk(resync_req, 1'b1, "R5", "cl resync");
    chk(los, 1'b1, "R5", "cl los");
    close_search("R9");
    for (int k = 0; k < 4; k++) begin
      feed(1'b1, 1, "R3 one");
      feed(1'b0, 7, "R3 zeros");
    end
    chk(carrier_loss, 1'b0, "R3", "released at 32");
    cl_resync_dis = 1'b1;
    feed(1'b0, 192, "R5 dis");
    chk(carrier_loss, 1'b1, "R5", "cl set");
    chk(resync_req, 1'b0, "R5", "no req when disabled");
    cl_resync_dis = 1'b0;
    for (int k = 0; k < 3; k++) begin
      feed(1'b1, 1, "R3 part");
      feed(1'b0, 7, "R3 part");
    end
    feed(1'b1, 7, "R3 part");
    chk(carrier_loss, 1'b1, "R3", "held at 31");
    feed(1'b1, 1, "R3 last");
    chk(carrier_loss, 1'b0, "R3", "released");
    auto_dis = 1'b1;
    oof_evt = 1'b1; fbit_mark = 1'b1; tick("R6 oof"); oof_evt = 1'b0; fbit_mark = 1'b0;
    chk(resync_req, 1'b0, "R6", "oof ignored");
    chk(los, 1'b0, "R6", "los low");
    man_trig = 1'b1; tick("R7 edge");
    chk(resync_req, 1'b1, "R7", "manual req");
    close_search("R7 hold");
    tick("R7 hold");
    chk(resync_req, 1'b0, "R7", "level no retrigger");
    man_trig = 1'b0;
    do_reset("R1 pulse");
    tick("R1 resync");
    chk(resync_req, 1'b1, "R1", "reset pulse req");
    auto_dis = 1'b0;

    for (int c = 0; c < 6000; c++) begin
      int ph;
      ph = (c / 400) % 3;
      rx_valid = ($urandom % 8) != 0;
      case (ph)
        0: rx_bit = ($urandom % 200) == 0;
        1: rx_bit = ($urandom % 6) == 0;
        default: rx_bit = ($urandom % 2) == 0;
      endcase
      oof_evt = ($urandom % 30) == 0;
      fbit_mark = ($urandom % 3) == 0;
      frame_found = ($urandom % 20) == 0;
      if (c % 500 == 0) auto_dis = ($urandom % 3) == 0;
      if (c % 700 == 0) cl_resync_dis = ($urandom % 2) == 0;
      if ($urandom % 25 == 0) man_trig = ~man_trig;
      if (c % 1500 == 1499) begin
        do_reset("RND R1");
      end else begin
        tick("RND");
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule